// File: doc/BRIEF.md
# Clock Generator Strap Latch and Bring-Up Sequencer

This block brings a clock generator out of power-on. After reset it idles until an active-low power-good strobe is first seen low, then counts a settling window in ticks of an external timebase. At the end of the window it captures the two frequency-select straps once, decodes them into a CPU frequency code, and enables the clock outputs. The strobe is one-shot. Once it has been seen low, later toggles on it or on the straps have no effect until the next reset.

A sticky test-mode bit, set from a configuration register, takes over the output mode. While it is set, strap B is ignored. The live, synchronised value of strap A, not the latched copy, chooses between a divided-reference output mode and an all-outputs-high-impedance mode. Test mode can be left only by reset. The strap pins double as reference clock outputs, so a pin-drive flag turns them into outputs once the straps are no longer needed.

All asynchronous pins pass through two-stage synchronisers. The reset is asserted asynchronously and released synchronously.

Top module: `clkgen_bringup`

## Requirements
- R1: During and after reset, and before the sequence has finished, `strap_q_o`=00, `cpu_sel_o`=00, `out_en_o`=0 and `pin_drive_o`=0. With the test bit clear, `mode_o`=00 (normal).
- R2: While `pwrgd_n_i` stays high, the block keeps waiting with outputs off. Ticks that arrive before power-good is seen low are not counted.
- R3: After power-good is first seen low, exactly SETTLE_TICKS timebase ticks must arrive before the outputs are enabled. With one tick fewer, `out_en_o` stays 0.
- R4: The straps are captured on the final settling tick, with strap A in bit 0 and strap B in bit 1 of `strap_q_o`. A strap change made during the window is therefore the value that is latched.
- R5: Once the outputs are enabled, later changes on `pwrgd_n_i`, `strap_a_i` or `strap_b_i` leave `strap_q_o` and `out_en_o` unchanged.
- R6: `cpu_sel_o` decodes the latched straps (A,B) as follows:
  - 00 gives 2'b00 (100 MHz)
  - 01 gives 2'b10 (200 MHz)
  - 10 gives 2'b01 (133 MHz)
  - 11 gives 2'b00
- R7: `mode_o` is 2'b00 (normal) while the test bit is clear. Once the test bit is set, `mode_o` follows the live strap A: A=0 gives 2'b01 (divided reference) and A=1 gives 2'b10 (high impedance). Strap B has no effect in this mode.
- R8: A single-cycle high on `test_en_i` sets test mode. Test mode stays set after `test_en_i` returns low, until reset clears it.
- R9: `out_en_o` is 1 only after the sequence has finished and while the mode is not high impedance. `pin_drive_o` is 1 only after the sequence has finished and while test mode is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Active-low reset (power cycle), asserted asynchronously |
| strap_a_i | input | 1 | Frequency-select strap A (asynchronous) |
| strap_b_i | input | 1 | Frequency-select strap B (asynchronous) |
| pwrgd_n_i | input | 1 | Active-low power-good strobe (asynchronous) |
| test_en_i | input | 1 | Test-mode configuration bit |
| tick_i | input | 1 | One-cycle timebase tick |
| strap_q_o | output | 2 | Latched straps: bit 0 = A, bit 1 = B |
| cpu_sel_o | output | 2 | CPU frequency code |
| mode_o | output | 2 | Output mode: 00 normal, 01 divided reference, 10 high impedance |
| out_en_o | output | 1 | Clock output enable |
| pin_drive_o | output | 1 | Strap pins switched to reference-clock output |

## Verification
The hardest situation to reach is a strap change that lands inside the settling window. The bench has to show that the value present on the final tick is the one latched, and not the value present when power-good fell. The bench holds the window open by delivering one tick fewer than required, checks that the outputs are still off, changes strap A, waits out the synchroniser, and then delivers the last tick. The other hard case is a live change of strap A while test mode is sticky. The bench clears `test_en_i` after the sequence has finished and toggles both straps, to show that strap B and the cleared bit are ignored.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_REFDIV = 2'b01,
    MD_HIZ    = 2'b10
  } out_mode_e;

  localparam logic [1:0] CPU_100 = 2'b00;
  localparam logic [1:0] CPU_133 = 2'b01;
  localparam logic [1:0] CPU_200 = 2'b10;
endpackage

// File: rtl/cbu_rst_sync.sv
module cbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) shift_q <= '0;
    else              shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/cbu_sync.sv
module cbu_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cbu_seq.sv
module cbu_seq
  import cbu_pkg::*;
#(
  parameter int SETTLE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_n_s,
  input  logic       tick,
  input  logic [1:0] straps_s,
  output seq_state_e state_o,
  output logic [1:0] strap_q_o
);
  localparam int             CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [1:0]       strap_q;
  logic             latch_en;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    latch_en = 1'b0;
    case (state_q)
      ST_OFF:  state_d = ST_WAIT;
      ST_WAIT: begin
        cnt_d = '0;
        if (!pg_n_s) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            latch_en = 1'b1;
            state_d  = ST_RUN;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign cnt_en = (state_q == ST_WAIT) || ((state_q == ST_SETTLE) && tick);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        strap_q <= '0;
    else if (latch_en) strap_q <= straps_s;
  end

  assign state_o   = state_q;
  assign strap_q_o = strap_q;

  // R2: no progress while power-good is still high
  a_r2_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && pg_n_s) |=> (state_q == ST_WAIT));

  // R3: settling only ends on a tick
  a_r3_settle_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && !tick) |=> (state_q == ST_SETTLE));

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (cnt_q <= LAST));

  // R5: one-shot, latched straps frozen while running
  a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (state_q == ST_RUN) && $stable(strap_q));
endmodule

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  input  logic       a_live,
  input  logic       run,
  input  logic [1:0] strap_q,
  output logic [1:0] cpu_sel,
  output out_mode_e  mode,
  output logic       out_en,
  output logic       pin_drive
);
  logic test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= 1'b0;
    else if (test_en) test_q <= 1'b1;
  end

  always_comb begin
    case (strap_q)
      2'b01:   cpu_sel = CPU_133;
      2'b10:   cpu_sel = CPU_200;
      default: cpu_sel = CPU_100;
    endcase
    if (!test_q)     mode = MD_NORMAL;
    else if (a_live) mode = MD_HIZ;
    else             mode = MD_REFDIV;
  end

  assign out_en    = run && (mode != MD_HIZ);
  assign pin_drive = run && !test_q;

  // R8: test mode only leaves through reset
  a_r8_test_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |=> test_q);

  // R7: in test mode a live strap A rise selects high impedance
  a_r7_live_a_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && $past(test_q) && a_live) |-> (mode == MD_HIZ));

  // R9: pins never driven as outputs while in test mode
  a_r9_no_drive_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |-> !pin_drive);
endmodule

// File: rtl/clkgen_bringup.sv
module clkgen_bringup
  import cbu_pkg::*;
#(
  parameter int SETTLE_TICKS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       strap_a_i,
  input  logic       strap_b_i,
  input  logic       pwrgd_n_i,
  input  logic       test_en_i,
  input  logic       tick_i,
  output logic [1:0] strap_q_o,
  output logic [1:0] cpu_sel_o,
  output logic [1:0] mode_o,
  output logic       out_en_o,
  output logic       pin_drive_o
);
  logic       rst_n;
  logic       pg_n_s;
  logic [1:0] straps_s;
  seq_state_e state;
  out_mode_e  mode;

  cbu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_i), .rst_n_async(rst_n_i), .rst_n_sync(rst_n));

  cbu_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk_i), .rst_n(rst_n), .d(pwrgd_n_i), .q(pg_n_s));

  cbu_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_strap_sync (
    .clk(clk_i), .rst_n(rst_n), .d({strap_b_i, strap_a_i}), .q(straps_s));

  cbu_seq #(.SETTLE_TICKS(SETTLE_TICKS)) u_seq (
    .clk(clk_i), .rst_n(rst_n), .pg_n_s(pg_n_s), .tick(tick_i),
    .straps_s(straps_s), .state_o(state), .strap_q_o(strap_q_o));

  cbu_decode u_dec (
    .clk(clk_i), .rst_n(rst_n), .test_en(test_en_i), .a_live(straps_s[0]),
    .run(state == ST_RUN), .strap_q(strap_q_o), .cpu_sel(cpu_sel_o),
    .mode(mode), .out_en(out_en_o), .pin_drive(pin_drive_o));

  assign mode_o = mode;

  // R1/R9: nothing enabled before the sequence has finished
  a_r1_off_until_run: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state != ST_RUN) |-> (!out_en_o && !pin_drive_o && strap_q_o == 2'b00));

  // R9: high impedance mode keeps outputs disabled
  a_r9_hiz_disabled: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_o == 2'b10) |-> !out_en_o);
endmodule

// File: tb/clkgen_bringup_tb_top.sv
`timescale 1ns/1ps
module clkgen_bringup_tb_top;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n, sa, sb, pg_n, ten, tick;
  logic [1:0] strap_q, cpu_sel, mode;
  logic out_en, pin_drive;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkgen_bringup #(.SETTLE_TICKS(SETTLE)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .strap_a_i(sa), .strap_b_i(sb),
    .pwrgd_n_i(pg_n), .test_en_i(ten), .tick_i(tick),
    .strap_q_o(strap_q), .cpu_sel_o(cpu_sel), .mode_o(mode),
    .out_en_o(out_en), .pin_drive_o(pin_drive));

  // {test, A, B, exp strap_q[1:0], exp cpu[1:0], exp mode[1:0], exp en}
  localparam logic [9:0] VEC [6] = '{
    10'b0_0_0_00_00_00_1,
    10'b0_0_1_10_10_00_1,
    10'b0_1_0_01_01_00_1,
    10'b0_1_1_11_00_00_1,
    10'b1_0_1_10_10_01_1,
    10'b1_1_0_01_01_10_0
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic t, input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; pg_n = 1'b1; tick = 1'b0; ten = t; sa = a; sb = b;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; wait_cyc(1);
      tick = 1'b0; wait_cyc(1);
    end
  endtask

  task automatic fall_pg();
    pg_n = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    rst_n = 1'b0; sa = 1'b0; sb = 1'b0; pg_n = 1'b1; ten = 1'b0; tick = 1'b0;
    wait_cyc(3);
    check("R1 strap_q in reset", strap_q, 0);
    check("R1 out_en in reset", out_en, 0);
    check("R1 pin_drive in reset", pin_drive, 0);
    check("R1 mode in reset", mode, 0);
    check("R1 cpu_sel in reset", cpu_sel, 0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [9:0] v;
      v = VEC[i];
      do_reset(v[9], v[8], v[7]);
      check("R1 off before power-good", out_en, 0);
      fall_pg();
      ticks(SETTLE);
      wait_cyc(2);
      check("R4 latched straps", strap_q, v[6:5]);
      check("R6 cpu code", cpu_sel, v[4:3]);
      check("R7 mode", mode, v[2:1]);
      check("R9 out_en", out_en, v[0]);
      check("R9 pin_drive", pin_drive, v[0] & ~v[9]);
    end

    // R2: ticks before power-good are ignored; R3: one tick short stays off
    do_reset(1'b0, 1'b0, 1'b0);
    ticks(SETTLE + 2);
    check("R2 off while power-good high", out_en, 0);
    fall_pg();
    ticks(SETTLE - 1);
    wait_cyc(2);
    check("R3 off one tick short", out_en, 0);
    check("R3 straps not yet latched", strap_q, 0);
    // R4: change strap A inside the window
    sa = 1'b1;
    wait_cyc(3);
    ticks(1);
    wait_cyc(2);
    check("R3 enabled after final tick", out_en, 1);
    check("R4 value at final tick latched", strap_q, 1);
    check("R6 133 code", cpu_sel, 1);

    // R5: later toggles ignored
    pg_n = 1'b1; sa = 1'b0; sb = 1'b1;
    wait_cyc(5);
    check("R5 strap_q after toggles", strap_q, 1);
    check("R5 out_en after power-good high", out_en, 1);
    pg_n = 1'b0;
    ticks(SETTLE);
    wait_cyc(2);
    check("R5 strap_q after second low", strap_q, 1);
    check("R5 cpu_sel unchanged", cpu_sel, 1);

    // R7/R8/R9 test mode, live strap A
    do_reset(1'b1, 1'b0, 1'b0);
    fall_pg();
    ticks(SETTLE);
    wait_cyc(2);
    check("R7 refdiv with A=0", mode, 1);
    check("R9 enabled in refdiv", out_en, 1);
    ten = 1'b0;
    sa = 1'b1;
    wait_cyc(4);
    check("R7 hiz with live A=1", mode, 2);
    check("R9 disabled in hiz", out_en, 0);
    check("R9 no pin drive in test", pin_drive, 0);
    check("R8 test stays after bit cleared", mode, 2);
    sb = 1'b1;
    wait_cyc(4);
    check("R7 strap B ignored", mode, 2);
    sa = 1'b0;
    wait_cyc(4);
    check("R7 back to refdiv", mode, 1);
    check("R5 latched straps frozen in test", strap_q, 0);
    do_reset(1'b0, 1'b0, 1'b0);
    check("R8 reset leaves test mode", mode, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule